// File: doc/BRIEF.md
# Cascaded BCD Score Display with Leading-Zero Suppression

This block holds a game score counted in steps of ten. The units position has no counter and always shows a zero. Behind the tens and hundreds positions sit two decimal digit counters in a chain. Every score pulse adds one to the tens counter. When the tens counter rolls over from nine to zero, it adds one to the hundreds counter. When the hundreds counter rolls over, the whole score wraps back to zero, so the largest score shown is 990.

Each counted digit passes through a shared seven-segment encoder with a blanking stage. The permission to blank ripples down from the most significant digit: the hundreds digit is blanked when it is zero, and the tens digit is blanked only if it is zero and everything above it was also blanked. A player-operated clear input is brought into the clock domain through a short synchroniser and then empties both counters. After a clear, only the fixed units zero is lit.

The score pulse and the clear are plain control pins with no handshake. The segment outputs are static levels, and the drive electronics sample them.

Top module: `score_board`

## Requirements
- R1: `seg_units` always carries the pattern for the digit 0, 7'h3F.
- R2: Each clock cycle in which `score` is high, with no clear in effect, adds ten to the displayed score. The tens digit steps 0..9 and then back to 0. Updated segments appear after the same rising edge that samples `score`.
- R3: A tens roll-over from 9 to 0 adds one to the hundreds digit in the same cycle.
- R4: The hundreds segment output is all zeros (dark) whenever the hundreds count is 0.
- R5: The tens segment output is dark only when the tens count and the hundreds count are both 0. When the hundreds count is non-zero, a tens count of 0 shows as 7'h3F.
- R6: `clr_btn` passes through SYNC_STAGES flip-flops (default 2). With the default, holding it high empties both counters at the third rising edge after it is first sampled. Until then the counts are unchanged.
- R7: While the synchronised clear is active, `score` pulses have no effect, and the display stays at the fixed units zero.
- R8: One score pulse at 990 wraps the score to 0, which shows as units zero with both counted digits dark.
- R9: Segment encoding is active high, with bit 0 = a through bit 6 = g. The digits 0..9 map to 3F,06,5B,4F,66,6D,7D,07,7F,6F. `seg_digits[6:0]` is the tens digit and `seg_digits[13:7]` is the hundreds digit.
- R10: While `rst_n` is low, both counters are 0 and the clear synchroniser is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| score | input | 1 | Score pulse, synchronous to clk, one step per high cycle |
| clr_btn | input | 1 | Manual clear, asynchronous, active high |
| seg_units | output | 7 | Fixed units digit pattern |
| seg_digits | output | 14 | Tens (low 7 bits) and hundreds segment patterns, blanking applied |

## Verification
The assertions assume that `score` is synchronous to `clk`. They also assume that `clr_btn` is held for longer than the synchroniser depth, so the clear is seen cleanly. The bench changes every input at the falling edge and holds each clear for several cycles. It reads the outputs at the next falling edge, half a cycle after the register update. It checks every score against a model kept in the bench.

// File: rtl/score_board_pkg.sv
package score_board_pkg;
  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  localparam bcd_t BCD_MAX   = 4'd9;
  localparam seg_t SEG_DARK  = 7'h00;

  // active-high, bit0 = a ... bit6 = g
  function automatic seg_t seg_encode(input bcd_t d);
    seg_t s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = SEG_DARK;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/clr_sync.sv
module clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chain_q[STAGES-2]) == chain_q[STAGES-1]) else $error("sync chain"); // R6
endmodule

// File: rtl/bcd_digit_ctr.sv
module bcd_digit_ctr
  import score_board_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output bcd_t cnt,
  output logic carry
);
  bcd_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (inc && carry)     cnt_q <= '0;
    else if (inc)              cnt_q <= cnt_q + 4'd1;
  end

  assign carry = inc && (cnt_q == BCD_MAX);
  assign cnt   = cnt_q;

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= BCD_MAX) else $error("digit range"); // R2
  AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> cnt_q == (($past(cnt_q) == BCD_MAX) ? 4'd0 : bcd_t'($past(cnt_q) + 4'd1))) else $error("digit step"); // R2
  AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q)) else $error("digit hold"); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == 4'd0) else $error("clear priority"); // R7
endmodule

// File: rtl/seg_blank_stage.sv
module seg_blank_stage
  import score_board_pkg::*;
(
  input  bcd_t digit,
  input  logic rb_in,
  output logic rb_out,
  output seg_t seg
);
  assign rb_out = rb_in && (digit == 4'd0);
  assign seg    = rb_out ? SEG_DARK : seg_encode(digit);
endmodule

// File: rtl/score_board.sv
module score_board
  import score_board_pkg::*;
#(
  parameter int NUM_DIGITS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    score,
  input  logic                    clr_btn,
  output logic [6:0]              seg_units,
  output logic [NUM_DIGITS*7-1:0] seg_digits
);
  localparam int SEG_W = 7;
  localparam int MSD   = NUM_DIGITS - 1;

  logic                  clr_s;
  logic [NUM_DIGITS:0]   inc_chain;
  logic [NUM_DIGITS:0]   rb_chain;
  bcd_t                  cnt   [NUM_DIGITS];
  seg_t                  seg_w [NUM_DIGITS];

  clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(clr_btn), .sync_out(clr_s)
  );

  assign inc_chain[0]          = score;
  assign rb_chain[NUM_DIGITS]  = 1'b1;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    bcd_digit_ctr u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(clr_s),
      .inc(inc_chain[i]), .cnt(cnt[i]), .carry(inc_chain[i+1])
    );
    seg_blank_stage u_blank (
      .digit(cnt[i]), .rb_in(rb_chain[i+1]),
      .rb_out(rb_chain[i]), .seg(seg_w[i])
    );
    assign seg_digits[i*SEG_W +: SEG_W] = seg_w[i];
  end

  assign seg_units = seg_encode(4'd0);

  AST_TOP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[MSD] == 4'd0) |-> (seg_digits[MSD*SEG_W +: SEG_W] == SEG_DARK)) else $error("msd blank"); // R4
  AST_LIT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[MSD] != 4'd0) |-> (seg_digits[0 +: SEG_W] != SEG_DARK)) else $error("lower lit"); // R5
  AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && score && cnt[0] == BCD_MAX && cnt[MSD] != BCD_MAX) |=> cnt[MSD] == bcd_t'($past(cnt[MSD]) + 4'd1)) else $error("carry"); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && inc_chain[NUM_DIGITS]) |=> (seg_digits == '0)) else $error("wrap"); // R8
endmodule

// File: tb/test_score_board.sv
module test_score_board;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        score = 1'b0;
  logic        clr_btn = 1'b0;
  logic [6:0]  seg_units;
  logic [13:0] seg_digits;

  int compared = 0;
  int mismatched = 0;
  int model = 0; // score / 10, 0..99

  always #2.5 clk = ~clk;

  score_board i_score_board (
    .clk(clk), .rst_n(rst_n), .score(score), .clr_btn(clr_btn),
    .seg_units(seg_units), .seg_digits(seg_digits)
  );

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F;
      4: pat = 7'h66; 5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07;
      8: pat = 7'h7F; default: pat = 7'h6F;
    endcase
  endfunction

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (model %0d)", req, act, exp, model);
    end
  endtask

  task automatic chk_display(input string req);
    int h = model / 10;
    int t = model % 10;
    logic [6:0] eh = (h == 0) ? 7'h00 : pat(h);
    logic [6:0] et = (h == 0 && t == 0) ? 7'h00 : pat(t);
    chk("R1", {7'h0, seg_units}, 14'h3F);
    chk(req, seg_digits, {eh, et});
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      score = 1'b1;
      @(negedge clk);
      score = 1'b0;
      model = (model + 1) % 100;
    end
  endtask

  task automatic do_clear();
    clr_btn = 1'b1;
    repeat (5) @(negedge clk);
    clr_btn = 1'b0;
    repeat (3) @(negedge clk);
    model = 0;
  endtask

  task t_reset();
    @(negedge clk);
    chk_display("R10");
    chk("R10", seg_digits, 14'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_display("R10");
  endtask

  task t_count();
    pulse(1); chk_display("R2");
    pulse(1); chk_display("R2");
    score = 1'b1; repeat (3) @(negedge clk); score = 1'b0; model += 3;
    chk_display("R2");
    repeat (3) @(negedge clk);
    chk_display("R2");
  endtask

  task t_carry();
    pulse(9 - model);                 // tens at 9, hundreds 0
    chk_display("R2");
    pulse(1);                         // 100: tens shows 0, lit
    chk_display("R3");
    chk("R5", {7'h0, seg_digits[6:0]}, 14'h3F);
    chk("R4", {7'h0, seg_digits[13:7]}, 14'h06);
    pulse(1);
    chk_display("R3");
  endtask

  task t_clear();
    pulse(3);
    clr_btn = 1'b1;
    @(negedge clk); @(negedge clk);
    chk_display("R6");                // two edges: not yet cleared
    @(negedge clk);
    model = 0;
    chk_display("R6");
    chk("R6", seg_digits, 14'h0);
    score = 1'b1;                     // clear still active
    repeat (3) @(negedge clk);
    score = 1'b0;
    chk("R7", seg_digits, 14'h0);
    chk("R7", {7'h0, seg_units}, 14'h3F);
    clr_btn = 1'b0;
    repeat (3) @(negedge clk);
    chk_display("R7");
  endtask

  task t_blank();
    pulse(5);
    chk_display("R5");
    chk("R4", {7'h0, seg_digits[13:7]}, 14'h0);
    pulse(95);                        // 100 total -> wrap to 0
    chk_display("R8");
  endtask

  task t_wrap();
    do_clear();
    pulse(99);
    chk_display("R9");
    chk("R9", seg_digits, {7'h6F, 7'h6F});
    pulse(1);
    chk_display("R8");
    chk("R8", seg_digits, 14'h0);
    pulse(10);
    chk_display("R3");
    chk("R9", seg_digits, {7'h06, 7'h3F});
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_carry();
    t_clear();
    t_blank();
    t_wrap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule